// File: doc/BRIEF.md
# Bus-Width Matching Word Queue

This block is a first-in first-out queue whose storage is one full word (40 bits by default) wide, while either its write port or its read port may be narrowed to half or a quarter of that width. A narrow write port collects consecutive pieces into one complete stored word. A narrow read port hands out a stored word piece by piece. The piece at the lowest bits always comes first. The write and read sides run on separate clocks. Pointers cross between the clock domains in Gray code through two-stage synchronizers.

The port widths come from three configuration inputs: a matching enable, an input-narrow select and an output-narrow select. Each clock domain captures them on every clock edge while the active-low reset is held. They are then frozen until the next reset. A narrow port carries its data on the low bits of the full-width data bus. The unused upper read-data bits are driven to zero.

Top module: `bmf_width_fifo`

## Requirements
- R1: With `cfg_bm` low, both ports are full width and each read returns one written word in write order.
- R2: With `cfg_bm`=1, `cfg_iw`=0 and `cfg_ow`=0, writes are full width and reads are half width. A word is read as bits [19:0] first, then bits [39:20].
- R3: With `cfg_bm`=1, `cfg_iw`=0 and `cfg_ow`=1, writes are full width and reads are quarter width. A word is read as four 10-bit pieces, lowest first: [9:0], [19:10], [29:20], [39:30].
- R4: With `cfg_bm`=1, `cfg_iw`=1 and `cfg_ow`=0, writes are half width and reads are full width. The first write piece, taken from `wr_data[19:0]`, becomes stored bits [19:0] and the second becomes bits [39:20].
- R5: With `cfg_bm`=1, `cfg_iw`=1 and `cfg_ow`=1, writes are quarter width and reads are full width. Four pieces from `wr_data[9:0]` fill the stored word from bit 0 upward.
- R6: The configuration inputs are captured only while `rst_n` is low. Changing them after reset has no effect on the port widths.
- R7: A partly assembled word is not visible to the reader. `rd_empty` stays high until the last piece of a word has been written.
- R8: On a narrowed read port, the `rd_data` bits above the piece width are zero.
- R9: After DEPTH complete words are stored without reads, `wr_full` is high. Writes while `wr_full` is high are dropped and are never read back.
- R10: A read request while `rd_empty` is high does nothing. `rd_data` keeps its value.
- R11: After reset, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R12: `wr_full` updates on the write edge that stores a word. `rd_empty` falls on the second read edge after that write edge, counting the first read edge that follows it, when both clocks are the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset for both sides; configuration is captured while low |
| cfg_bm | input | 1 | Width-matching enable (low: both ports full width) |
| cfg_iw | input | 1 | Narrow-write select when matching is enabled |
| cfg_ow | input | 1 | Selects quarter (high) or half (low) for the narrow port |
| wr_en | input | 1 | Write one piece or word on this write edge |
| wr_data | input | WORD_W | Write data; a narrow port uses the low bits |
| wr_full | output | 1 | No room for another complete word |
| rd_en | input | 1 | Read one piece or word on this read edge |
| rd_data | output | WORD_W | Registered read data, upper bits zero when narrowed |
| rd_empty | output | 1 | No complete word is available to the reader |

## Verification
The bench drives every input at a falling edge and samples every output at the next falling edge.

- `rd_data` is due right after the rising edge that accepts the read, so it is sampled one falling edge after the request.
- `wr_full` is due on the rising edge of the storing write, so it is sampled on the falling edge just after it.
- For `rd_empty`, the bench samples at each of the first three falling edges after a completing write. It expects high, high, then low. This pins the two-stage synchronizer delay exactly.
- Everywhere else, three idle cycles are allowed before the reader is used. This lets pointer synchronization finish before the bench reads.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

   typedef enum logic [1:0] {
      BW_FULL    = 2'd0,
      BW_HALF    = 2'd1,
      BW_QUARTER = 2'd2
   } width_t;

   function automatic width_t wr_width_of(input logic bm, input logic iw, input logic ow);
      if (!bm || !iw) return BW_FULL;
      return ow ? BW_QUARTER : BW_HALF;
   endfunction

   function automatic width_t rd_width_of(input logic bm, input logic iw, input logic ow);
      if (!bm || iw) return BW_FULL;
      return ow ? BW_QUARTER : BW_HALF;
   endfunction

endpackage

// File: rtl/bmf_mode_latch.sv
module bmf_mode_latch
   import bmf_pkg::*;
#(
   parameter bit WRITE_SIDE = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cfg_bm,
   input  logic   cfg_iw,
   input  logic   cfg_ow,
   output width_t mode
);

   width_t sel_w;

   generate
      if (WRITE_SIDE) begin : g_wr
         assign sel_w = wr_width_of(cfg_bm, cfg_iw, cfg_ow);
      end else begin : g_rd
         assign sel_w = rd_width_of(cfg_bm, cfg_iw, cfg_ow);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) mode <= sel_w;
   end

endmodule

// File: rtl/bmf_pack.sv
module bmf_pack
   import bmf_pkg::*;
#(
   parameter int WORD_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  width_t            mode,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              full,
   output logic              push,
   output logic [WORD_W-1:0] push_data
);

   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   logic [WORD_W-1:0] acc;
   logic [1:0]        slot;
   logic              accept;
   logic              last;
   logic [WORD_W-1:0] merged;

   assign accept = wr_en && !full;

   always_comb begin
      merged = acc;
      last   = 1'b1;
      unique case (mode)
         BW_HALF: begin
            merged[int'(slot[0]) * HALF_W +: HALF_W] = wr_data[HALF_W-1:0];
            last = slot[0];
         end
         BW_QUARTER: begin
            merged[int'(slot) * QTR_W +: QTR_W] = wr_data[QTR_W-1:0];
            last = (slot == 2'd3);
         end
         default: begin
            merged = wr_data;
            last   = 1'b1;
         end
      endcase
   end

   assign push      = accept && last;
   assign push_data = merged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         slot <= '0;
      end else if (accept) begin
         if (last) begin
            acc  <= '0;
            slot <= '0;
         end else begin
            acc  <= merged;
            slot <= slot + 2'd1;
         end
      end
   end

endmodule

// File: rtl/bmf_store.sv
module bmf_store #(
   parameter int WORD_W = 40,
   parameter int DEPTH  = 16
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   output logic              full,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic              empty
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bmf_store: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];

   logic [PW-1:0] wbin, wgray, rbin, rgray;
   logic [PW-1:0] rgray_s1, rgray_s2, wgray_s1, wgray_s2;
   logic [PW-1:0] wbin_nx, rbin_nx;

   assign wbin_nx = wbin + 1'b1;
   assign rbin_nx = rbin + 1'b1;

   always_ff @(posedge wr_clk) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (push) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wr_clk) begin
      if (push) mem[wbin[AW-1:0]] <= push_data;
   end

   always_ff @(posedge wr_clk) begin
      if (!rst_n) begin
         rgray_s1 <= '0;
         rgray_s2 <= '0;
      end else begin
         rgray_s1 <= rgray;
         rgray_s2 <= rgray_s1;
      end
   end

   always_ff @(posedge rd_clk) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (pop) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   always_ff @(posedge rd_clk) begin
      if (!rst_n) begin
         wgray_s1 <= '0;
         wgray_s2 <= '0;
      end else begin
         wgray_s1 <= wgray;
         wgray_s2 <= wgray_s1;
      end
   end

   assign full  = (wgray == {~rgray_s2[PW-1:PW-2], rgray_s2[PW-3:0]});
   assign empty = (rgray == wgray_s2);
   assign head  = mem[rbin[AW-1:0]];

endmodule

// File: rtl/bmf_unpack.sv
module bmf_unpack
   import bmf_pkg::*;
#(
   parameter int WORD_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  width_t            mode,
   input  logic              rd_en,
   input  logic              empty,
   input  logic [WORD_W-1:0] head,
   output logic              pop,
   output logic [WORD_W-1:0] rd_data
);

   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   logic [1:0]        sel;
   logic              fire;
   logic              last;
   logic [WORD_W-1:0] piece;

   assign fire = rd_en && !empty;

   always_comb begin
      piece = '0;
      last  = 1'b1;
      unique case (mode)
         BW_HALF: begin
            piece[HALF_W-1:0] = head[int'(sel[0]) * HALF_W +: HALF_W];
            last = sel[0];
         end
         BW_QUARTER: begin
            piece[QTR_W-1:0] = head[int'(sel) * QTR_W +: QTR_W];
            last = (sel == 2'd3);
         end
         default: begin
            piece = head;
            last  = 1'b1;
         end
      endcase
   end

   assign pop = fire && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel     <= '0;
         rd_data <= '0;
      end else if (fire) begin
         rd_data <= piece;
         sel     <= last ? 2'd0 : sel + 2'd1;
      end
   end

endmodule

// File: rtl/bmf_width_fifo.sv
module bmf_width_fifo
   import bmf_pkg::*;
#(
   parameter int WORD_W = 40,
   parameter int DEPTH  = 16
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              cfg_bm,
   input  logic              cfg_iw,
   input  logic              cfg_ow,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_empty
);

   generate
      if (WORD_W < 4 || (WORD_W % 4) != 0) begin : g_bad_width
         $error("bmf_width_fifo: WORD_W must be a positive multiple of 4");
      end
   endgenerate

   width_t            wr_mode, rd_mode;
   logic              push_w, pop_w;
   logic [WORD_W-1:0] push_data_w, head_w;

   bmf_mode_latch #(.WRITE_SIDE(1'b1)) u_wr_mode (
      .clk(wr_clk), .rst_n(rst_n),
      .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
      .mode(wr_mode)
   );

   bmf_mode_latch #(.WRITE_SIDE(1'b0)) u_rd_mode (
      .clk(rd_clk), .rst_n(rst_n),
      .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
      .mode(rd_mode)
   );

   bmf_pack #(.WORD_W(WORD_W)) u_pack (
      .clk(wr_clk), .rst_n(rst_n), .mode(wr_mode),
      .wr_en(wr_en), .wr_data(wr_data), .full(wr_full),
      .push(push_w), .push_data(push_data_w)
   );

   bmf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .push(push_w), .push_data(push_data_w), .full(wr_full),
      .pop(pop_w), .head(head_w), .empty(rd_empty)
   );

   bmf_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk(rd_clk), .rst_n(rst_n), .mode(rd_mode),
      .rd_en(rd_en), .empty(rd_empty), .head(head_w),
      .pop(pop_w), .rd_data(rd_data)
   );

endmodule

// File: rtl/bmf_width_fifo_chk.sv
module bmf_width_fifo_chk
   import bmf_pkg::*;
#(
   parameter int WORD_W = 40
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input width_t            wr_mode,
   input width_t            rd_mode,
   input logic              push_w,
   input logic              pop_w,
   input logic              wr_full,
   input logic              rd_empty,
   input logic [WORD_W-1:0] rd_data
);

   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   assert_wr_mode_frozen_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      rst_n |=> $stable(wr_mode));

   assert_rd_mode_frozen_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rst_n |=> $stable(rd_mode));

   assert_no_store_when_full_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      push_w |-> !wr_full);

   assert_no_take_when_empty_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
      pop_w |-> !rd_empty);

   assert_half_pad_zero_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_mode == BW_HALF) |-> (rd_data[WORD_W-1:HALF_W] == '0));

   assert_quarter_pad_zero_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_mode == BW_QUARTER) |-> (rd_data[WORD_W-1:QTR_W] == '0));

   assert_held_when_empty_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_empty |=> $stable(rd_data));

endmodule

bind bmf_width_fifo bmf_width_fifo_chk #(.WORD_W(WORD_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
   .wr_mode(wr_mode), .rd_mode(rd_mode),
   .push_w(push_w), .pop_w(pop_w),
   .wr_full(wr_full), .rd_empty(rd_empty), .rd_data(rd_data)
);

// File: tb/bmf_width_fifo_bench.sv
module bmf_width_fifo_bench;

   localparam int W     = 40;
   localparam int DEPTH = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_bm = 1'b0, cfg_iw = 1'b0, cfg_ow = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_full, rd_empty;
   logic [W-1:0] rd_data;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   bmf_width_fifo #(.WORD_W(W), .DEPTH(DEPTH)) u_bmf_width_fifo (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
      .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
      .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
      .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic bm, input logic iw, input logic ow);
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      cfg_bm = bm; cfg_iw = iw; cfg_ow = ow;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put(input logic [W-1:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic take(input string req, input logic [W-1:0] exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, rd_data, exp);
   endtask

   task automatic idle3();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset(1'b0, 1'b0, 1'b0);
      chk("R11 empty", W'(rd_empty), W'(1));
      chk("R11 full", W'(wr_full), W'(0));
      chk("R11 data", rd_data, '0);
   endtask

   task automatic t_full_width();
      do_reset(1'b0, 1'b0, 1'b0);
      put(40'h11_2233_4455);
      chk("R12 empty e1", W'(rd_empty), W'(1));
      @(negedge clk);
      chk("R12 empty e2", W'(rd_empty), W'(1));
      @(negedge clk);
      chk("R12 empty e3", W'(rd_empty), W'(0));
      put(40'h66_7788_99AA);
      put(40'hBB_CCDD_EEFF);
      idle3();
      take("R1 word0", 40'h11_2233_4455);
      take("R1 word1", 40'h66_7788_99AA);
      take("R1 word2", 40'hBB_CCDD_EEFF);
      chk("R1 drained", W'(rd_empty), W'(1));
   endtask

   task automatic t_wide_to_half();
      do_reset(1'b1, 1'b0, 1'b0);
      put(40'hA5A5A_3C3C3);
      put(40'h12345_6789A);
      idle3();
      take("R2 w0 lo", {20'h0, 20'h3C3C3});
      chk("R8 half pad", {20'h0, rd_data[19:0]}, rd_data);
      take("R2 w0 hi", {20'h0, 20'hA5A5A});
      take("R2 w1 lo", {20'h0, 20'h6789A});
      take("R2 w1 hi", {20'h0, 20'h12345});
      chk("R2 drained", W'(rd_empty), W'(1));
   endtask

   task automatic t_wide_to_quarter();
      logic [W-1:0] w;
      do_reset(1'b1, 1'b0, 1'b1);
      w = 40'hFF_EDCB_A987;
      put(w);
      idle3();
      for (int i = 0; i < 4; i++) begin
         take("R3 piece", {30'h0, w[i*10 +: 10]});
         if (i < 3) chk("R3 not empty mid-word", W'(rd_empty), W'(0));
      end
      chk("R8 quarter pad", rd_data >> 10, '0);
      chk("R3 drained", W'(rd_empty), W'(1));
   endtask

   task automatic t_half_to_wide();
      do_reset(1'b1, 1'b1, 1'b0);
      put({20'hFFFFF, 20'h0BEEF});
      idle3();
      chk("R7 half partial hidden", W'(rd_empty), W'(1));
      put({20'hFFFFF, 20'hCAFE1});
      idle3();
      take("R4 packed", 40'hCAFE1_0BEEF);
   endtask

   task automatic t_quarter_to_wide();
      logic [W-1:0] w;
      do_reset(1'b1, 1'b1, 1'b1);
      w = 40'h3C_5A69_0F1E;
      for (int i = 0; i < 3; i++) put({30'h3FFFFFFF, w[i*10 +: 10]});
      idle3();
      chk("R7 quarter partial hidden", W'(rd_empty), W'(1));
      put({30'h3FFFFFFF, w[30 +: 10]});
      idle3();
      take("R5 packed", w);
   endtask

   task automatic t_config_locked();
      do_reset(1'b0, 1'b0, 1'b0);
      cfg_bm = 1'b1; cfg_iw = 1'b1; cfg_ow = 1'b1;
      put(40'h87_6543_2101);
      idle3();
      chk("R6 word stored from one write", W'(rd_empty), W'(0));
      take("R6 full word read", 40'h87_6543_2101);
      chk("R6 drained", W'(rd_empty), W'(1));
      cfg_bm = 1'b0; cfg_iw = 1'b0; cfg_ow = 1'b0;
   endtask

   task automatic t_full_and_drop();
      do_reset(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) begin
         if (i == DEPTH - 1) chk("R9 not full before last", W'(wr_full), W'(0));
         put(40'h50_0000_0000 + W'(i));
      end
      chk("R12 R9 full on storing edge", W'(wr_full), W'(1));
      put(40'hDE_AD00_0BAD);
      idle3();
      for (int i = 0; i < DEPTH; i++) take("R9 order", 40'h50_0000_0000 + W'(i));
      chk("R9 dropped word absent", W'(rd_empty), W'(1));
      idle3();
      chk("R9 full clears", W'(wr_full), W'(0));
   endtask

   task automatic t_read_when_empty();
      logic [W-1:0] held;
      held = rd_data;
      take("R10 data held", held);
      take("R10 data held again", held);
      chk("R10 still empty", W'(rd_empty), W'(1));
   endtask

   initial begin
      fork
         begin
            t_reset_state();
            t_full_width();
            t_wide_to_half();
            t_wide_to_quarter();
            t_half_to_wide();
            t_quarter_to_wide();
            t_config_locked();
            t_full_and_drop();
            t_read_when_empty();
         end
         begin
            repeat (100000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule